// File: doc/BRIEF.md
# Selectable Clock Fanout Divider

This block is a synthesizable behavioural model of a clock distribution core. It chooses one source clock in two levels: a first select picks one of two single-ended inputs, and a second select picks either that result or a third input that stands for a differential receiver, modelled here as a plain digital clock. From the chosen source it builds a full-rate copy and a divide-by-two copy, both launched from the same rising-edge flop so that their rising edges coincide.

Fifteen outputs are grouped into three banks of five. Each bank has its own rate select, and one shared select forces every bank to half rate. A single active-high hold pin clears the divider at once and floats every output. Releasing it passes through a short synchronizer on the source clock, so the divider always restarts cleanly from a low level.

Top module: `clkfan_core`

## Requirements
- R1: With the differential select low, a low first-level select routes `se_clk0_i` and a high one routes `se_clk1_i` as the source clock.
- R2: With the differential select high, `diff_clk_i` is the source, and the first-level select has no effect on any output.
- R3: Bank b drives `clk_out_o[5*b+4:5*b]`. A bank runs at half rate when its `bank_half_i[b]` bit or `all_half_i` is 1, and at full rate when both are 0. A full-rate output has the same period as the source.
- R4: A half-rate output has a period of exactly twice the source period.
- R5: Every rising edge of a half-rate output falls on the same source edge as a rising edge of every full-rate output. At that edge all fifteen outputs are high together.
- R6: While `hold_hiz_i` is 1, all fifteen outputs are high impedance and `out_en_o` is 0. This takes effect without waiting for a clock edge.
- R7: After `hold_hiz_i` falls, `out_en_o` rises and all outputs are driven low at the second source rising edge. The first output rising edge comes at the third source rising edge, and the half-rate phase starts from low.
- R8: While `out_en_o` is 1, no output is high impedance or unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| se_clk0_i | input | 1 | Single-ended clock, routed when the first-level select is 0 |
| se_clk1_i | input | 1 | Single-ended clock, routed when the first-level select is 1 |
| diff_clk_i | input | 1 | Clock from the differential receiver path, as a digital level |
| se_pick_i | input | 1 | First-level select between the single-ended clocks |
| diff_pick_i | input | 1 | 1 selects the differential-path clock over the single-ended result |
| bank_half_i | input | 3 | Per-bank rate select, 1 = half rate |
| all_half_i | input | 1 | Shared select forcing half rate on every bank |
| hold_hiz_i | input | 1 | Active-high reset of the divider and float of all outputs |
| clk_out_o | output | 15 | Tristate clock outputs, five per bank |
| out_en_o | output | 1 | High while the outputs are driven |

## Verification
The assertions assume that the chosen source clock keeps running, and that the source and rate selects stay fixed while the outputs are enabled. A select change in mid-stream would put a runt pulse on the muxed clock, and the alternation and alignment properties do not cover that case. The stimulus therefore changes every select only while the hold pin is high. After each release it waits many source periods before it measures periods or samples edge alignment. It releases the hold between source edges, never on one.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

  function automatic rate_e bank_rate(input logic own_sel, input logic shared_sel);
    return (own_sel | shared_sel) ? RATE_HALF : RATE_FULL;
  endfunction

endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux (
  input  logic se_clk0_i,
  input  logic se_clk1_i,
  input  logic diff_clk_i,
  input  logic se_pick_i,
  input  logic diff_pick_i,
  output logic src_clk_o
);

  logic se_clk;

  always_comb begin
    se_clk    = se_pick_i ? se_clk1_i : se_clk0_i;
    src_clk_o = diff_pick_i ? diff_clk_i : se_clk;
  end

endmodule

// File: rtl/clkfan_rst_sync.sv
module clkfan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic hold_i,
  output logic run_o
);

  logic              arst_n;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign arst_n = ~hold_i;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign run_o = chain_q[STAGES-1];

  // R6
  always @(posedge clk_i) begin
    if (hold_i) begin
      hold_blocks_run_chk: assert (!run_o);
    end
  end

endmodule

// File: rtl/clkfan_divider.sv
module clkfan_divider (
  input  logic clk_i,
  input  logic run_i,
  output logic full_o,
  output logic half_o
);

  logic rise_q, rise_d;
  logic fall_q, fall_d;
  logic tog_en;

  assign tog_en = run_i;

  always_comb begin
    rise_d = tog_en ? ~rise_q : rise_q;
    fall_d = tog_en ? rise_q  : fall_q;
  end

  always_ff @(posedge clk_i or negedge run_i) begin
    if (!run_i) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge clk_i or negedge run_i) begin
    if (!run_i) fall_q <= 1'b0;
    else        fall_q <= fall_d;
  end

  assign half_o = rise_q;
  assign full_o = rise_q ^ fall_q;

  // R4
  half_alternates_chk: assert property (@(posedge clk_i) disable iff (!run_i)
    1'b1 |=> (half_o != $past(half_o)));

  // R3
  full_low_at_rise_chk: assert property (@(posedge clk_i) disable iff (!run_i)
    !full_o);

  // R5
  half_rise_aligned_chk: assert property (@(negedge clk_i) disable iff (!run_i)
    $rose(half_o) |-> full_o);

endmodule

// File: rtl/clkfan_bank.sv
module clkfan_bank
  import clkfan_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             full_i,
  input  logic             half_i,
  input  logic             own_half_i,
  input  logic             all_half_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] pad_o
);

  rate_e rate;
  logic  drive;

  always_comb begin
    rate  = bank_rate(own_half_i, all_half_i);
    drive = (rate == RATE_HALF) ? half_i : full_i;
  end

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_pin
      assign pad_o[k] = oe_i ? drive : 1'bz;
    end
  endgenerate

endmodule

// File: rtl/clkfan_core.sv
module clkfan_core #(
  parameter int NUM_OUT     = 15,
  parameter int NUM_BANKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 se_clk0_i,
  input  logic                 se_clk1_i,
  input  logic                 diff_clk_i,
  input  logic                 se_pick_i,
  input  logic                 diff_pick_i,
  input  logic [NUM_BANKS-1:0] bank_half_i,
  input  logic                 all_half_i,
  input  logic                 hold_hiz_i,
  output logic [NUM_OUT-1:0]   clk_out_o,
  output logic                 out_en_o
);

  localparam int BANK_W = NUM_OUT / NUM_BANKS;

  logic src_clk;
  logic run;
  logic full_clk;
  logic half_clk;

  clkfan_src_mux u_mux (
    .se_clk0_i  (se_clk0_i),
    .se_clk1_i  (se_clk1_i),
    .diff_clk_i (diff_clk_i),
    .se_pick_i  (se_pick_i),
    .diff_pick_i(diff_pick_i),
    .src_clk_o  (src_clk)
  );

  clkfan_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (src_clk),
    .hold_i(hold_hiz_i),
    .run_o (run)
  );

  clkfan_divider u_div (
    .clk_i (src_clk),
    .run_i (run),
    .full_o(full_clk),
    .half_o(half_clk)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      clkfan_bank #(.WIDTH(BANK_W)) u_bank (
        .full_i    (full_clk),
        .half_i    (half_clk),
        .own_half_i(bank_half_i[b]),
        .all_half_i(all_half_i),
        .oe_i      (run),
        .pad_o     (clk_out_o[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  assign out_en_o = run;

  // R8
  no_float_when_on_chk: assert property (@(negedge src_clk) disable iff (!run)
    (^clk_out_o) !== 1'bx);

endmodule

// File: tb/clkfan_core_tb.sv
`timescale 1ns/1ps
module clkfan_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ALT_PERIOD = 16;
  localparam int DIF_PERIOD = 24;
  localparam int NOUT       = 15;
  localparam int NB         = 3;
  localparam int BW         = 5;
  localparam int NVEC       = 6;

  // {se_pick, diff_pick, all_half, bank_half[2:0], source period}
  localparam logic [13:0] VECS [0:NVEC-1] = '{
    {1'b0, 1'b0, 1'b0, 3'b000, 8'd10},
    {1'b1, 1'b0, 1'b0, 3'b101, 8'd16},
    {1'b0, 1'b1, 1'b0, 3'b010, 8'd24},
    {1'b1, 1'b1, 1'b0, 3'b010, 8'd24},
    {1'b0, 1'b0, 1'b1, 3'b000, 8'd10},
    {1'b1, 1'b0, 1'b0, 3'b111, 8'd16}
  };

  logic clk0 = 1'b0, clk1 = 1'b0, dclk = 1'b0;
  logic se_pick, diff_pick, all_half, hold;
  logic [NB-1:0] bank_half;
  logic [NOUT-1:0] clk_out;
  logic out_en;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk0 = ~clk0;
  always #(ALT_PERIOD/2) clk1 = ~clk1;
  always #(DIF_PERIOD/2) dclk = ~dclk;

  clkfan_core dut_i (
    .se_clk0_i  (clk0),
    .se_clk1_i  (clk1),
    .diff_clk_i (dclk),
    .se_pick_i  (se_pick),
    .diff_pick_i(diff_pick),
    .bank_half_i(bank_half),
    .all_half_i (all_half),
    .hold_hiz_i (hold),
    .clk_out_o  (clk_out),
    .out_en_o   (out_en)
  );

  task automatic check(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 15000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    hold = 1'b1; se_pick = 1'b0; diff_pick = 1'b0; all_half = 1'b0; bank_half = '0;
    #(CLK_PERIOD*2 + 3);
    // R6: reset state
    check(clk_out === {NOUT{1'bz}} && out_en === 1'b0, "R6",
          $sformatf("actual out=%b en=%b expected all z en=0", clk_out, out_en));

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      int per;
      int trig;
      logic [NB-1:0] halfm;
      hold = 1'b1;
      #7;
      {se_pick, diff_pick, all_half, bank_half} = VECS[v][13:8];
      per   = int'(VECS[v][7:0]);
      halfm = bank_half | {NB{all_half}};
      #(DIF_PERIOD + 3);
      hold = 1'b0;
      #(DIF_PERIOD * 12);
      for (int b = 0; b < NB; b++) begin
        longint t1, t2;
        int exp_p;
        exp_p = halfm[b] ? 2*per : per;
        @(posedge clk_out[b*BW]); t1 = $time;
        @(posedge clk_out[b*BW]); t2 = $time;
        // R1 R2 R3 R4: period per bank follows source and rate
        check(int'(t2 - t1) == exp_p, halfm[b] ? "R4" : (diff_pick ? "R2" : "R1"),
              $sformatf("vec %0d bank %0d actual period %0d expected %0d (R3)",
                        v, b, t2 - t1, exp_p));
      end
      trig = 0;
      for (int b = NB-1; b >= 0; b--) if (halfm[b]) trig = b*BW;
      @(posedge clk_out[trig]);
      #1;
      // R5 R8: every output high right after a half-rate rise
      check(clk_out === {NOUT{1'b1}}, "R5",
            $sformatf("vec %0d actual %b expected all ones (R8)", v, clk_out));
    end

    // R7: release timing on se_clk0_i, all banks full rate except bank 1
    hold = 1'b1;
    {se_pick, diff_pick, all_half, bank_half} = {1'b0, 1'b0, 1'b0, 3'b010};
    @(negedge clk0); #1;
    hold = 1'b0;
    @(posedge clk0); #1;
    check(out_en === 1'b0 && clk_out === {NOUT{1'bz}}, "R7",
          $sformatf("edge1 actual en=%b out=%b expected en=0 all z", out_en, clk_out));
    @(posedge clk0); #1;
    check(out_en === 1'b1 && clk_out === {NOUT{1'b0}}, "R7",
          $sformatf("edge2 actual en=%b out=%b expected en=1 all 0", out_en, clk_out));
    @(posedge clk0); #1;
    check(clk_out === {NOUT{1'b1}}, "R7",
          $sformatf("edge3 actual %b expected all ones", clk_out));
    @(posedge clk0); #1;
    check(clk_out === {{BW{1'b1}}, {BW{1'b0}}, {BW{1'b1}}}, "R7",
          $sformatf("edge4 actual %b expected bank1 low others high", clk_out));

    // R6: hold in mid-run floats at once, no clock edge
    @(posedge clk0); #2;
    hold = 1'b1;
    #1;
    check(clk_out === {NOUT{1'bz}} && out_en === 1'b0, "R6",
          $sformatf("async actual out=%b en=%b expected all z en=0", clk_out, out_en));

    // R2: first-level select toggled under differential source, no effect
    {se_pick, diff_pick, all_half, bank_half} = {1'b0, 1'b1, 1'b0, 3'b000};
    #3; hold = 1'b0;
    #(DIF_PERIOD * 6);
    se_pick = 1'b1;
    begin
      longint t1, t2;
      @(posedge clk_out[14]); t1 = $time;
      @(posedge clk_out[14]); t2 = $time;
      check(int'(t2 - t1) == DIF_PERIOD, "R2",
            $sformatf("ignored select actual period %0d expected %0d", t2 - t1, DIF_PERIOD));
    end
    #1;
    check(out_en === 1'b1, "R8", $sformatf("actual en=%b expected 1", out_en));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule